// File: doc/BRIEF.md
# Debug Read Command Sequencer

This block is the target side of a single-wire debug link, and it serves memory reads. A bit receiver upstream hands it one sampled host bit at a time. The block builds an opcode from these bits, then a memory address. It wins a cycle on the system bus and reads the location. It then tells the host the data is ready by pulling the open-drain debug pin low for a fixed time. A one-cycle high drive follows to speed up the pin's return to high. After that, a 16-bit word goes to a transmit shifter for the host to clock out.

There is no fixed response delay. The acknowledge is timed from the last command bit and from when the bus data arrives, whichever is later. If the CPU enters a low-power mode before the read executes, the command is dropped and no acknowledge is given.

One clock cycle of the block equals one debug-clock tick. The `bit_valid` strobe marks the cycle in which a host bit has been sampled (its 16th tick).

States:
- `S_OPC`: collect opcode bits.
- `S_ADDR`: collect address bits.
- `S_DECODE`: one cycle of decode.
- `S_BUS`: request the bus.
- `S_CAPT`: capture the read data.
- `S_WAIT`: hold off until the spacing rule is met.
- `S_LOW`: acknowledge low phase.
- `S_SPEED`: speed-up drive.
- `S_SEND`: offer the word to the shifter.

Transitions:
- `S_OPC` moves to `S_ADDR` once eight bits hold a read opcode. Any other opcode is cleared and the block stays in `S_OPC`.
- `S_ADDR` moves to `S_DECODE` once all address bits are in.
- `S_DECODE` always moves to `S_BUS`.
- `S_BUS` moves to `S_CAPT` on grant.
- `S_CAPT` always moves to `S_WAIT`.
- `S_WAIT` moves to `S_LOW` when the spacing is met.
- `S_LOW` moves to `S_SPEED` after the last low cycle.
- `S_SPEED` always moves to `S_SEND`.
- `S_SEND` moves to `S_OPC` on `tx_done`.
- From `S_ADDR`, `S_DECODE` and `S_BUS`, a `cpu_sleep` cycle returns the block to `S_OPC`.

Top module: `dbg_read_seq`

## Requirements
- R1: After a synchronous reset, `pin_oe`, `bus_req` and `tx_valid` are all 0.
- R2: Bits are taken MSB first: an 8-bit opcode, then a 16-bit address for opcode 0xE0 (byte read) or 0xE8 (word read). `bus_req` rises exactly 3 cycles after the cycle of the last address bit, with `bus_addr` equal to the address received.
- R3: Any opcode other than 0xE0 or 0xE8 is discarded after its 8 bits: no bus request and no acknowledge follow, and the next 24 bits are taken as a fresh command.
- R4: `bus_req` stays high through every cycle without `bus_gnt` and is low in the cycle after the grant cycle. `bus_rdata` is sampled in the cycle after the grant.
- R5: The acknowledge low phase (`pin_oe`=1, `pin_out`=0) lasts exactly 16 consecutive cycles.
- R6: Let C be the cycle of the last command bit and G the grant cycle. The low phase starts in cycle max(C+32, G+3), and so never earlier than 32 cycles after C.
- R7: The cycle right after the low phase drives `pin_oe`=1, `pin_out`=1 for exactly one cycle. After that, `pin_oe` is 0.
- R8: A word read returns `bus_rdata` unchanged. A byte read at an even address returns {`bus_rdata`[15:8], 8'h00}. At an odd address it returns {8'h00, `bus_rdata`[7:0]}.
- R9: `tx_valid` rises in the cycle after the speed-up cycle. It holds with `tx_word` stable until `tx_done`, and is low in the cycle after `tx_done`.
- R10: A `cpu_sleep` cycle while a read is pending (address received, data not yet captured) drops `bus_req` in the next cycle. No acknowledge and no `tx_valid` follow, and the next command is served normally.
- R11: A reset in the middle of a command discards the bits collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock, one cycle per tick |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One-cycle strobe: a host bit has been sampled |
| bit_data | input | 1 | Value of the sampled host bit |
| cpu_sleep | input | 1 | CPU entering a wait or stop mode |
| bus_req | output | 1 | Bus cycle request |
| bus_addr | output | 16 | Read address |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | 16 | Aligned read word, valid the cycle after grant |
| pin_oe | output | 1 | Debug pin output enable |
| pin_out | output | 1 | Debug pin drive value |
| tx_valid | output | 1 | Word ready for the transmit shifter |
| tx_word | output | 16 | Word to transmit |
| tx_done | input | 1 | Shifter has sent all 16 bits |

## Verification
The bench keeps a free-running cycle number and records the cycle of every host bit it drives. It logs the first request cycle, the grant cycle, the first low cycle and the speed-up cycle at falling edges, so each is checked against its formula: the request 3 cycles after the last bit, the low phase at max(C+32, G+3) for 16 cycles, the speed-up in the next cycle, and `tx_valid` one cycle later. Grant delays on both sides of the point where the bus, rather than the spacing rule, sets the acknowledge time are swept across both opcodes and both address parities. Drops caused by sleep, reset or an unknown opcode are each checked in the cycle after the event, then over a quiet window of cycles, and then by one correct follow-up command.

// File: rtl/dbg_read_pkg.sv
package dbg_read_pkg;
    localparam int OP_W = 8;
    localparam logic [OP_W-1:0] OPC_RD_BYTE = 8'hE0;
    localparam logic [OP_W-1:0] OPC_RD_WORD = 8'hE8;

    typedef enum logic [3:0] {
        S_OPC, S_ADDR, S_DECODE, S_BUS, S_CAPT,
        S_WAIT, S_LOW, S_SPEED, S_SEND
    } seq_state_t;
endpackage

// File: rtl/dbg_cmd_shift.sv
module dbg_cmd_shift #(
    parameter int TOTAL_W = 24,
    localparam int CW = $clog2(TOTAL_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               clr,
    input  logic               bit_valid,
    input  logic               bit_data,
    output logic [TOTAL_W-1:0] shreg,
    output logic [CW-1:0]      count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg <= '0;
            count <= '0;
        end else if (en && bit_valid && count < CW'(TOTAL_W)) begin
            shreg <= {shreg[TOTAL_W-2:0], bit_data};
            count <= count + 1'b1;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(TOTAL_W));
endmodule

// File: rtl/dbg_gap_timer.sv
module dbg_gap_timer #(
    parameter int GAP_MIN = 32,
    localparam int GW = $clog2(GAP_MIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_valid,
    output logic [GW-1:0] gap_cnt
);
    // gap_cnt equals the number of cycles since the latest host bit, saturating
    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt <= '0;
        else if (bit_valid)
            gap_cnt <= GW'(1);
        else if (gap_cnt < GW'(GAP_MIN))
            gap_cnt <= gap_cnt + 1'b1;
    end
endmodule

// File: rtl/dbg_lane_pick.sv
module dbg_lane_pick #(
    parameter int DATA_W = 16,
    localparam int LANE = DATA_W / 2
) (
    input  logic              is_word,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        if (is_word)
            word = rdata;
        else if (addr_lsb)
            word = {{LANE{1'b0}}, rdata[LANE-1:0]};
        else
            word = {rdata[DATA_W-1:LANE], {LANE{1'b0}}};
    end
endmodule

// File: rtl/dbg_read_seq.sv
module dbg_read_seq
    import dbg_read_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int ACK_LEN = 16,
    parameter int GAP_MIN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              cpu_sleep,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              pin_oe,
    output logic              pin_out,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_word,
    input  logic              tx_done
);
    localparam int TOTAL_W = OP_W + ADDR_W;
    localparam int CW      = $clog2(TOTAL_W + 1);
    localparam int GW      = $clog2(GAP_MIN + 1);
    localparam int LW      = $clog2(ACK_LEN);

    seq_state_t        state, state_nx;
    logic [TOTAL_W-1:0] shreg;
    logic [CW-1:0]      count;
    logic [GW-1:0]      gap_cnt;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  word_q, picked;
    logic [LW-1:0]      lcnt;
    logic               word_op;
    logic               shift_en, shift_clr;
    logic               is_read, op_seen, addr_seen, gap_ok, ack_low;

    dbg_cmd_shift #(.TOTAL_W(TOTAL_W)) u_shift (
        .clk(clk), .rst(rst), .en(shift_en), .clr(shift_clr),
        .bit_valid(bit_valid), .bit_data(bit_data),
        .shreg(shreg), .count(count)
    );

    dbg_gap_timer #(.GAP_MIN(GAP_MIN)) u_gap (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .gap_cnt(gap_cnt)
    );

    dbg_lane_pick #(.DATA_W(DATA_W)) u_lane (
        .is_word(word_op), .addr_lsb(addr_q[0]),
        .rdata(bus_rdata), .word(picked)
    );

    assign is_read   = (shreg[OP_W-1:0] == OPC_RD_BYTE) ||
                       (shreg[OP_W-1:0] == OPC_RD_WORD);
    assign op_seen   = (state == S_OPC)  && (count == CW'(OP_W));
    assign addr_seen = (state == S_ADDR) && (count == CW'(TOTAL_W));
    assign gap_ok    = gap_cnt >= GW'(GAP_MIN - 1);

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_OPC;
            addr_q  <= '0;
            word_q  <= '0;
            word_op <= 1'b0;
            lcnt    <= '0;
        end else begin
            state <= state_nx;
            if (addr_seen) begin
                addr_q  <= shreg[ADDR_W-1:0];
                word_op <= (shreg[TOTAL_W-1 -: OP_W] == OPC_RD_WORD);
            end
            if (state == S_CAPT)
                word_q <= picked;
            lcnt <= (state == S_LOW) ? lcnt + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OPC:    if (op_seen) state_nx = is_read ? S_ADDR : S_OPC;
            S_ADDR:   if (cpu_sleep) state_nx = S_OPC;
                      else if (addr_seen) state_nx = S_DECODE;
            S_DECODE: state_nx = cpu_sleep ? S_OPC : S_BUS;
            S_BUS:    if (cpu_sleep) state_nx = S_OPC;
                      else if (bus_gnt) state_nx = S_CAPT;
            S_CAPT:   state_nx = S_WAIT;
            S_WAIT:   if (gap_ok) state_nx = S_LOW;
            S_LOW:    if (lcnt == LW'(ACK_LEN - 1)) state_nx = S_SPEED;
            S_SPEED:  state_nx = S_SEND;
            S_SEND:   if (tx_done) state_nx = S_OPC;
            default:  state_nx = S_OPC;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (state == S_BUS);
        bus_addr  = addr_q;
        pin_oe    = (state == S_LOW) || (state == S_SPEED);
        pin_out   = (state == S_SPEED);
        tx_valid  = (state == S_SEND);
        tx_word   = word_q;
        shift_en  = ((state == S_OPC) && (count < CW'(OP_W))) || (state == S_ADDR);
        shift_clr = !((state == S_OPC) || (state == S_ADDR)) ||
                    (op_seen && !is_read) || ((state == S_ADDR) && cpu_sleep);
        ack_low   = pin_oe && !pin_out;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt && !cpu_sleep |=> bus_req);
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt |=> !bus_req);
    assert_sleep_abort_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req && cpu_sleep |=> !bus_req && !pin_oe);
    assert_ack_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_oe) |-> gap_cnt >= GW'(GAP_MIN));
    assert_low_to_speed_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_low) |-> pin_oe && pin_out);
    assert_speed_release_R7: assert property (@(posedge clk) disable iff (rst)
        pin_oe && pin_out |=> !pin_oe && tx_valid);
    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_done |=> tx_valid && $stable(tx_word));
endmodule

// File: tb/dbg_read_seq_tb.sv
module dbg_read_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0, bit_data = 1'b0, cpu_sleep = 1'b0, tx_done = 1'b0;
    logic        gnt_en = 1'b0;
    logic        bus_req, bus_gnt, pin_oe, pin_out, tx_valid;
    logic [15:0] bus_addr, bus_rdata, tx_word;

    always #5 clk = ~clk;

    assign bus_gnt   = bus_req & gnt_en;
    assign bus_rdata = {bus_addr[7:0] ^ 8'h5A, bus_addr[15:8] ^ 8'hC3};

    dbg_read_seq u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
        .cpu_sleep(cpu_sleep), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
        .pin_out(pin_out), .tx_valid(tx_valid), .tx_word(tx_word), .tx_done(tx_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor of event cycles, sampled at falling edges
    bit mon_on = 1'b0;
    int last_c, req_cyc, gnt_cyc, low_start, low_cnt, hi_cnt, hi_cyc, tx_cyc, req_cnt, oe_cnt, txv_cnt;
    logic [15:0] req_addr;

    task automatic mon_clear();
        req_cyc = -1; gnt_cyc = -1; low_start = -1; low_cnt = 0; hi_cnt = 0;
        hi_cyc = -1; tx_cyc = -1; req_cnt = 0; oe_cnt = 0; txv_cnt = 0; req_addr = '0;
    endtask

    always @(negedge clk) if (mon_on) begin
        if (bus_req) begin
            if (req_cyc < 0) begin req_cyc = cyc; req_addr = bus_addr; end
            req_cnt++;
            if (bus_gnt && gnt_cyc < 0) gnt_cyc = cyc;
        end
        if (pin_oe) oe_cnt++;
        if (pin_oe && !pin_out) begin
            if (low_start < 0) low_start = cyc;
            low_cnt++;
        end
        if (pin_oe && pin_out) begin hi_cnt++; hi_cyc = cyc; end
        if (tx_valid) begin
            txv_cnt++;
            if (tx_cyc < 0) tx_cyc = cyc;
        end
    end

    task automatic send_bits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_data = v[i]; last_c = cyc;
            @(negedge clk);
            bit_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run_read(input logic [7:0] op, input logic [15:0] addr, input int gdel);
        logic [15:0] rd, expw, w;
        int expect_low;
        mon_clear();
        mon_on = 1'b1;
        gnt_en = (gdel == 0);
        send_bits({op, addr}, 24);
        for (int k = 0; k < 50 && !bus_req; k++) @(negedge clk);
        if (gdel > 0) begin
            repeat (gdel) @(negedge clk);
            gnt_en = 1'b1;
        end
        @(negedge clk);
        gnt_en = 1'b0;
        for (int k = 0; k < 200 && !tx_valid; k++) @(negedge clk);
        #1;
        rd   = {addr[7:0] ^ 8'h5A, addr[15:8] ^ 8'hC3};
        expw = (op == 8'hE8) ? rd : (addr[0] ? {8'h00, rd[7:0]} : {rd[15:8], 8'h00});
        expect_low = (last_c + 32 > gnt_cyc + 3) ? last_c + 32 : gnt_cyc + 3;
        chk(req_cyc == last_c + 3, "R2 request cycle", req_cyc, last_c + 3);
        chk(req_addr == addr, "R2 bus address", int'(req_addr), int'(addr));
        chk(req_cnt == gnt_cyc - req_cyc + 1, "R4 request held to grant", req_cnt, gnt_cyc - req_cyc + 1);
        chk(low_start == expect_low, "R6 acknowledge start", low_start, expect_low);
        chk(low_start - last_c >= 32, "R6 minimum spacing", low_start - last_c, 32);
        chk(low_cnt == 16, "R5 low phase length", low_cnt, 16);
        chk(hi_cnt == 1 && hi_cyc == low_start + 16, "R7 speed-up cycle", hi_cyc, low_start + 16);
        chk(tx_cyc == hi_cyc + 1, "R9 tx_valid cycle", tx_cyc, hi_cyc + 1);
        chk(tx_word == expw, "R8 returned word", int'(tx_word), int'(expw));
        w = tx_word;
        repeat (3) @(negedge clk);
        chk(tx_valid && tx_word == w && !pin_oe, "R9 word held, R7 pin released", int'(tx_word), int'(w));
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(!tx_valid, "R9 cleared after tx_done", int'(tx_valid), 0);
        mon_on = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] ops [2];
        int gdels [6];
        ops = '{8'hE0, 8'hE8};
        gdels = '{0, 1, 28, 29, 30, 40};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!pin_oe && !bus_req && !tx_valid, "R1 reset state", int'({pin_oe, bus_req, tx_valid}), 0);

        for (int o = 0; o < 2; o++)
            for (int a = 0; a < 8; a++)
                for (int g = 0; g < 6; g++)
                    run_read(ops[o], 16'(a * 16'h0301 + a), gdels[g]);

        // R3: unknown opcode discarded
        mon_clear(); mon_on = 1'b1;
        send_bits({16'h0000, 8'h3C}, 8);
        repeat (60) @(negedge clk);
        chk(req_cnt == 0 && oe_cnt == 0, "R3 unknown opcode ignored", req_cnt + oe_cnt, 0);
        mon_on = 1'b0;
        run_read(8'hE0, 16'h2345, 0);

        // R10: sleep while pending
        mon_clear(); mon_on = 1'b1;
        gnt_en = 1'b0;
        send_bits({8'hE8, 16'h4444}, 24);
        for (int k = 0; k < 50 && !bus_req; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        cpu_sleep = 1'b1;
        @(negedge clk);
        cpu_sleep = 1'b0;
        chk(!bus_req, "R10 request dropped", int'(bus_req), 0);
        mon_clear();
        repeat (80) @(negedge clk);
        chk(oe_cnt == 0 && txv_cnt == 0, "R10 no acknowledge", oe_cnt + txv_cnt, 0);
        mon_on = 1'b0;
        run_read(8'hE8, 16'h4445, 3);

        // R11: reset in the middle of a command
        send_bits(24'hE0_1234 >> 12, 12);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!pin_oe && !bus_req && !tx_valid, "R11 idle after reset", int'({pin_oe, bus_req, tx_valid}), 0);
        run_read(8'hE0, 16'h1357, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule